// File: doc/BRIEF.md
# One-Time Array Write Guard

This block sits behind the serial front end of a small byte-wide non-volatile memory. It decides whether each write may reach the array and whether each control byte is acknowledged. The front end hands it four kinds of input: a decoded control byte (a 4-bit control code plus the read/write bit), a strobe for each received data byte together with the byte's target address, a strobe for the stop condition that ends a sequence, and the level of an external lock pin.

The block holds a one-time lock flag. A write sequence addressed to the lock register sets the flag, and only a power-on reset clears it. While the flag is set, the lower half of the array refuses writes. The lock pin refuses writes to the whole array whatever the flag holds. A write that is refused is still acknowledged and still starts the full write-cycle timer. Software learns the flag state by whether a control byte addressed to the lock register is acknowledged.

All outputs are registered single-cycle pulses. Each appears in the cycle after the strobe that caused it.

Top module: `wp_guard`

## Requirements
- R1: A control byte with code 1010 (array access) is acknowledged, for read or write, whatever the flag and the lock pin hold.
- R2: A control byte with code 0110 (lock register), read or write, is acknowledged only while the flag is clear.
- R3: A 0110 write that receives at least one data byte and ends with a stop while the pin is low sets the flag. Its address and data are ignored, and it commits nothing.
- R4: Once set, the flag survives the protocol reset `rst`. Only `por` clears it.
- R5: With the flag set and the pin low, a data byte aimed at addresses 00h to 7Fh (address bit 7 = 0) does not commit, and one aimed at 80h to FFh commits. This is judged byte by byte within a page.
- R6: With the pin high, no data byte commits, at any address or flag state.
- R7: With the pin high, a 0110 write is acknowledged while the flag is clear, but it leaves the flag clear.
- R8: A stop that ends an acknowledged write sequence (array or lock register) with at least one data byte pulses `cycle_start`, whether or not any byte committed.
- R9: A 0110 write cut off by `rst` or by a new control byte before its stop does not set the flag.
- R10: A stop that ends a read sequence, or one with no data byte, does not pulse `cycle_start`.
- R11: `ctl_ack`, `commit_en` and `cycle_start` are single-cycle pulses in the cycle after `ctl_valid`, `byte_valid` and `seq_stop` respectively, and are low at all other times.
- R12: In the cycle after `rst` or `por`, all outputs are low.
- R13: After an unacknowledged control byte, later data bytes commit nothing and the stop starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous protocol reset, active high; leaves the flag alone |
| por | input | 1 | Synchronous power-on reset, active high; also clears the flag |
| ctl_valid | input | 1 | Control byte received (start or repeated start) |
| ctl_code | input | 4 | Control code of the control byte |
| ctl_rd | input | 1 | Read/write bit of the control byte, 1 = read |
| byte_valid | input | 1 | Data byte received in a write sequence |
| byte_addr | input | 8 | Array address targeted by that data byte |
| seq_stop | input | 1 | Stop condition received |
| hw_lock | input | 1 | Lock pin level, 1 = whole array locked |
| ctl_ack | output | 1 | Pulse: acknowledge the control byte |
| commit_en | output | 1 | Pulse: commit this data byte to the array |
| cycle_start | output | 1 | Pulse: start the write-cycle timer |

## Verification
The bench targets the addresses 7Fh and 80h on either side of the lock boundary, and a page that lies wholly in the locked half. A design that decoded the wrong address bit, or judged only the first byte of a page, would commit a locked byte or refuse a free one. It sends lock-register writes while the pin is high and writes that are cut off by `rst` or by a repeated start. A design that sampled the pin wrongly or set the flag before the stop would lose its lock-register acknowledge too early. It also checks that refused writes still start the timer, and that the flag survives `rst` and is cleared only by `por`. Getting these wrong would show as a missing `cycle_start` or a wrong acknowledge.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    SES_IDLE     = 2'd0,
    SES_ARRAY_WR = 2'd1,
    SES_LOCK_WR  = 2'd2,
    SES_READ     = 2'd3
  } ses_t;
endpackage

// File: rtl/wp_ack_decide.sv
module wp_ack_decide #(
  parameter int                CODE_W     = 4,
  parameter logic [CODE_W-1:0] ARRAY_CODE = 4'b1010,
  parameter logic [CODE_W-1:0] LOCK_CODE  = 4'b0110
) (
  input  logic [CODE_W-1:0] code,
  input  logic              lock_set,
  output logic              ack,
  output logic              is_lock
);
  logic is_array;
  always_comb begin
    is_array = (code == ARRAY_CODE);
    is_lock  = (code == LOCK_CODE);
    // the lock register answers only until it has been programmed
    ack      = is_array || (is_lock && !lock_set);
  end
endmodule

// File: rtl/wp_lock_reg.sv
module wp_lock_reg (
  input  logic clk,
  input  logic por,
  input  logic set_req,
  output logic lock_q
);
  // one-time flag: power-on reset is the only way back to zero
  always_ff @(posedge clk) begin
    if (por)          lock_q <= 1'b0;
    else if (set_req) lock_q <= 1'b1;
  end
endmodule

// File: rtl/wp_commit_gate.sv
module wp_commit_gate #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock_set,
  input  logic              hw_lock,
  output logic              allow
);
  localparam int HALF_BIT = ADDR_W - 1;
  logic low_half;
  always_comb begin
    low_half = !addr[HALF_BIT];
    allow    = !hw_lock && !(lock_set && low_half);
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int                CODE_W     = 4,
  parameter int                ADDR_W     = 8,
  parameter logic [CODE_W-1:0] ARRAY_CODE = 4'b1010,
  parameter logic [CODE_W-1:0] LOCK_CODE  = 4'b0110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              ctl_valid,
  input  logic [CODE_W-1:0] ctl_code,
  input  logic              ctl_rd,
  input  logic              byte_valid,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              seq_stop,
  input  logic              hw_lock,
  output logic              ctl_ack,
  output logic              commit_en,
  output logic              cycle_start
);
  import wp_pkg::*;

  ses_t ses_q;
  logic data_seen_q;
  logic lock_q;
  logic dec_ack, dec_is_lock, gate_allow;
  logic wr_session, stop_only, set_req;

  wp_ack_decide #(
    .CODE_W(CODE_W), .ARRAY_CODE(ARRAY_CODE), .LOCK_CODE(LOCK_CODE)
  ) u_dec (
    .code(ctl_code), .lock_set(lock_q), .ack(dec_ack), .is_lock(dec_is_lock)
  );

  wp_commit_gate #(.ADDR_W(ADDR_W)) u_gate (
    .addr(byte_addr), .lock_set(lock_q), .hw_lock(hw_lock), .allow(gate_allow)
  );

  always_comb begin
    wr_session = (ses_q == SES_ARRAY_WR) || (ses_q == SES_LOCK_WR);
    stop_only  = seq_stop && !ctl_valid && !byte_valid;
    set_req    = stop_only && !rst && (ses_q == SES_LOCK_WR)
                 && data_seen_q && !hw_lock;
  end

  wp_lock_reg u_lock (
    .clk(clk), .por(por), .set_req(set_req), .lock_q(lock_q)
  );

  always_ff @(posedge clk) begin
    if (rst || por) begin
      ses_q       <= SES_IDLE;
      data_seen_q <= 1'b0;
      ctl_ack     <= 1'b0;
      commit_en   <= 1'b0;
      cycle_start <= 1'b0;
    end else begin
      ctl_ack     <= 1'b0;
      commit_en   <= 1'b0;
      cycle_start <= 1'b0;
      if (ctl_valid) begin
        ctl_ack     <= dec_ack;
        data_seen_q <= 1'b0;
        if (!dec_ack)         ses_q <= SES_IDLE;
        else if (ctl_rd)      ses_q <= SES_READ;
        else if (dec_is_lock) ses_q <= SES_LOCK_WR;
        else                  ses_q <= SES_ARRAY_WR;
      end else if (byte_valid) begin
        if (ses_q == SES_ARRAY_WR) commit_en <= gate_allow;
        if (wr_session) data_seen_q <= 1'b1;
      end else if (seq_stop) begin
        cycle_start <= wr_session && data_seen_q;
        ses_q       <= SES_IDLE;
        data_seen_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int                CODE_W     = 4,
  parameter int                ADDR_W     = 8,
  parameter logic [CODE_W-1:0] ARRAY_CODE = 4'b1010,
  parameter logic [CODE_W-1:0] LOCK_CODE  = 4'b0110
) (
  input logic              clk,
  input logic              rst,
  input logic              por,
  input logic              ctl_valid,
  input logic [CODE_W-1:0] ctl_code,
  input logic              byte_valid,
  input logic [ADDR_W-1:0] byte_addr,
  input logic              seq_stop,
  input logic              hw_lock,
  input logic              lock_q,
  input logic              ctl_ack,
  input logic              commit_en,
  input logic              cycle_start
);
  // R1
  array_ack_chk: assert property (@(posedge clk) disable iff (rst || por)
    (ctl_valid && ctl_code == ARRAY_CODE) |=> ctl_ack);

  // R2
  lock_nack_chk: assert property (@(posedge clk) disable iff (rst || por)
    (ctl_valid && ctl_code == LOCK_CODE && lock_q) |=> !ctl_ack);

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (por)
    lock_q |=> lock_q);

  // R5
  low_half_chk: assert property (@(posedge clk) disable iff (rst || por)
    (byte_valid && lock_q && !byte_addr[ADDR_W-1]) |=> !commit_en);

  // R6
  pin_block_chk: assert property (@(posedge clk) disable iff (rst || por)
    (byte_valid && hw_lock) |=> !commit_en);

  // R7
  pin_noset_chk: assert property (@(posedge clk) disable iff (por)
    (!lock_q && hw_lock) |=> !lock_q);

  // R11
  start_after_stop_chk: assert property (@(posedge clk) disable iff (rst || por)
    cycle_start |-> $past(seq_stop));

  // R11
  commit_after_byte_chk: assert property (@(posedge clk) disable iff (rst || por)
    commit_en |-> $past(byte_valid));
endmodule

bind wp_guard wp_guard_chk #(
  .CODE_W(CODE_W), .ADDR_W(ADDR_W), .ARRAY_CODE(ARRAY_CODE), .LOCK_CODE(LOCK_CODE)
) u_chk (
  .clk(clk), .rst(rst), .por(por), .ctl_valid(ctl_valid), .ctl_code(ctl_code),
  .byte_valid(byte_valid), .byte_addr(byte_addr), .seq_stop(seq_stop),
  .hw_lock(hw_lock), .lock_q(lock_q), .ctl_ack(ctl_ack), .commit_en(commit_en),
  .cycle_start(cycle_start)
);

// File: tb/test_wp_guard.sv
module test_wp_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] ARR = 4'b1010;
  localparam logic [3:0] LCK = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b0, por = 1'b0;
  logic ctl_valid = 1'b0, ctl_rd = 1'b0, byte_valid = 1'b0, seq_stop = 1'b0, hw_lock = 1'b0;
  logic [3:0] ctl_code = 4'd0;
  logic [7:0] byte_addr = 8'd0;
  logic ctl_ack, commit_en, cycle_start;

  wp_guard i_wp_guard (
    .clk(clk), .rst(rst), .por(por), .ctl_valid(ctl_valid), .ctl_code(ctl_code),
    .ctl_rd(ctl_rd), .byte_valid(byte_valid), .byte_addr(byte_addr),
    .seq_stop(seq_stop), .hw_lock(hw_lock), .ctl_ack(ctl_ack),
    .commit_en(commit_en), .cycle_start(cycle_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    due;
    logic  ack;
    logic  com;
    logic  st;
    string tag;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(logic a, logic c, logic s, string tag);
    exp_t e;
    e.due = cyc + 1; e.ack = a; e.com = c; e.st = s; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare at the falling edge, after the registered outputs settle
  always @(negedge clk) begin
    if (mon_on) begin
      n_chk++;
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        if ({ctl_ack, commit_en, cycle_start} !== {e.ack, e.com, e.st}) begin
          n_fail++;
          $display("FAIL %s: ack/commit/start actual %b%b%b expected %b%b%b",
                   e.tag, ctl_ack, commit_en, cycle_start, e.ack, e.com, e.st);
        end
      end else if ({ctl_ack, commit_en, cycle_start} !== 3'b000) begin
        n_fail++;
        $display("FAIL R11 idle cycle: actual %b%b%b expected 000",
                 ctl_ack, commit_en, cycle_start);
      end
    end
  end

  task automatic ctl(logic [3:0] code, logic rd, logic exp_ack, string tag);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_code = code; ctl_rd = rd;
    push(exp_ack, 1'b0, 1'b0, tag);
    @(negedge clk);
    ctl_valid = 1'b0;
  endtask

  task automatic wbyte(logic [7:0] addr, logic exp_com, string tag);
    @(negedge clk);
    byte_valid = 1'b1; byte_addr = addr;
    push(1'b0, exp_com, 1'b0, tag);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic stop(logic exp_st, string tag);
    @(negedge clk);
    seq_stop = 1'b1;
    push(1'b0, 1'b0, exp_st, tag);
    @(negedge clk);
    seq_stop = 1'b0;
  endtask

  task automatic pulse_rst(bit power);
    @(negedge clk);
    if (power) por = 1'b1; else rst = 1'b1;
    @(negedge clk);
    por = 1'b0; rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    por = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    por = 1'b0;
    n_chk++;
    if ({ctl_ack, commit_en, cycle_start} !== 3'b000) begin
      n_fail++;
      $display("FAIL R12 reset: actual %b%b%b expected 000", ctl_ack, commit_en, cycle_start);
    end
    mon_on = 1'b1;

    // plain byte write, flag clear, pin low
    ctl(ARR, 0, 1, "R1 array write ack");
    wbyte(8'h10, 1, "R5 free commit");
    stop(1, "R8 write timer");
    // status read of lock register while clear
    ctl(LCK, 1, 1, "R2 status ack while clear");
    stop(0, "R10 read stop no timer");
    // pin high: lock write acked, flag stays clear
    hw_lock = 1'b1;
    ctl(LCK, 0, 1, "R7 lock write ack pin high");
    wbyte(8'h00, 0, "R3 lock data not committed");
    stop(1, "R8 lock write timer");
    ctl(LCK, 1, 1, "R7 flag still clear");
    stop(0, "R10 read stop");
    ctl(ARR, 0, 1, "R1 array ack pin high");
    wbyte(8'h90, 0, "R6 pin blocks upper");
    stop(1, "R8 blocked write timed");
    hw_lock = 1'b0;
    // lock write cut off by rst, then by repeated start
    ctl(LCK, 0, 1, "R2 lock write ack");
    wbyte(8'h55, 0, "R3 data ignored");
    pulse_rst(0);
    ctl(LCK, 1, 1, "R9 rst abort keeps flag clear");
    stop(0, "R10 read stop");
    ctl(LCK, 0, 1, "R2 lock write ack");
    wbyte(8'h55, 0, "R3 data ignored");
    ctl(ARR, 1, 1, "R1 repeated start read");
    stop(0, "R10 read stop");
    ctl(LCK, 1, 1, "R9 repeated start keeps flag clear");
    stop(0, "R10 read stop");
    // lock write with no data byte: no timer, no set
    ctl(LCK, 0, 1, "R2 lock write ack");
    stop(0, "R10 stop without data");
    ctl(LCK, 1, 1, "R3 no data no set");
    stop(0, "R10 read stop");
    // real programming
    ctl(LCK, 0, 1, "R3 program ack");
    wbyte(8'hA5, 0, "R3 program data ignored");
    stop(1, "R8 program timer");
    ctl(LCK, 1, 0, "R2 status nack once set");
    ctl(LCK, 0, 0, "R2 write nack once set");
    wbyte(8'h80, 0, "R13 no commit after nack");
    stop(0, "R13 no timer after nack");
    pulse_rst(0);
    ctl(LCK, 1, 0, "R4 flag survives rst");
    // per-byte lower-half gating
    ctl(ARR, 0, 1, "R1 array ack locked");
    wbyte(8'h7F, 0, "R5 7F locked");
    wbyte(8'h80, 1, "R5 80 free");
    wbyte(8'h00, 0, "R5 00 locked");
    wbyte(8'hFF, 1, "R5 FF free");
    stop(1, "R8 mixed page timer");
    ctl(ARR, 0, 1, "R1 array ack");
    for (int i = 0; i < 4; i++) wbyte(8'h70 + 8'(i), 0, "R5 locked page byte");
    stop(1, "R8 fully blocked page timed");
    hw_lock = 1'b1;
    ctl(ARR, 0, 1, "R1 ack pin high locked");
    wbyte(8'hC0, 0, "R6 pin blocks with flag");
    stop(1, "R8 blocked timed");
    ctl(ARR, 1, 1, "R1 array read ack");
    stop(0, "R10 read stop");
    hw_lock = 1'b0;
    ctl(4'b1111, 0, 0, "R13 foreign code nack");
    wbyte(8'hF0, 0, "R13 no commit");
    stop(0, "R13 no timer");
    pulse_rst(1);
    ctl(LCK, 1, 1, "R4 por clears flag");
    stop(0, "R10 read stop");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R11 scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule